// File: doc/BRIEF.md
# Integer-to-Float Register Move Datapath

This block carries a 64-bit value taken from an integer register into the 64-bit image that a floating-point register holds. In wide mode the value passes through bit for bit. In single mode only the low word is used. It is read as a single-precision pattern and rewritten as the double-precision encoding of the same number. Infinities and NaNs keep their payload bits in place, and denormals are normalized. Alongside the data the block can produce a 4-bit condition field from the full 64-bit input, for instructions that record a comparison against zero.

Each operation is offered with a one-cycle `in_valid` strobe, and its result appears on the registered outputs exactly one clock later. There is no ready signal and no back-pressure: a new operation can be offered every cycle, and the consumer must take each result in the cycle `out_valid` is high. Between operations the data and condition outputs hold their last values. The block never touches floating-point status.

Top module: `fmv_gpr2fpr`

## Requirements
- R1: With `in_single` = 0, `out_data` equals `in_data` exactly, one cycle after `in_valid`.
- R2: With `in_single` = 1, bits 63..32 of `in_data` have no effect on `out_data`.
- R3: With `in_single` = 1 and input bits 30..23 all ones, `out_data[63]` = input bit 31, `out_data[62:52]` = 0x7FF, `out_data[51:29]` = input bits 22..0 and `out_data[28:0]` = 0.
- R4: With `in_single` = 1 and a normal input (exponent field 1..254), the output exponent is the input exponent plus 896 and the output fraction is the 23 input fraction bits followed by 29 zeros. A zero of either sign becomes a 64-bit zero of the same sign.
- R5: With `in_single` = 1, exponent field 0 and nonzero fraction, the output is normalized. If the leading one is at fraction bit 22-k, the fraction is shifted left by k+1, the 23 bits that remain form the top of the 52-bit output fraction, and the output exponent is 896-k.
- R6: When `in_record` = 1, `out_cr` is loaded with bit 3 = LT (input bit 63), bit 2 = GT (LT clear and input nonzero), bit 1 = EQ (input zero), bit 0 = `in_so`.
- R7: The condition field is computed from all 64 input bits, also in single mode.
- R8: `out_valid` is high exactly one cycle after each `in_valid`, and `out_cr_we` is high in that cycle only when `in_record` was 1.
- R9: `out_data` changes only after a valid input, and `out_cr` changes only after a valid input with `in_record` = 1. Otherwise both hold.
- R10: After reset, `out_valid`, `out_cr_we`, `out_data` and `out_cr` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation strobe, one per operation |
| in_data | input | 64 | Integer register value |
| in_single | input | 1 | 1: widen low word from single precision; 0: pass through |
| in_record | input | 1 | 1: also write the condition field |
| in_so | input | 1 | Summary-overflow bit copied into the condition field |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_data | output | 64 | Floating-point register image |
| out_cr | output | 4 | Condition field {LT, GT, EQ, SO} |
| out_cr_we | output | 1 | Condition field write enable |

## Verification
The hardest case to reach from the ports is the denormal path. Every position of the leading one selects a different shift and exponent, and a fault in the leading-zero count shows up at only one of them. The stimulus therefore walks a single one across all 23 fraction bits, then adds dense fractions at both ends. Each input carries random-looking upper bits, so the same stimulus also shows that single mode ignores the high word while the condition field still depends on it.

// File: rtl/fmv_pkg.sv
`timescale 1ns/1ps
package fmv_pkg;
  localparam int DW        = 64;
  localparam int SW        = 32;
  localparam int S_EXP_W   = 8;
  localparam int S_FRAC_W  = 23;
  localparam int D_EXP_W   = 11;
  localparam int D_FRAC_W  = 52;
  localparam int FRAC_PAD  = D_FRAC_W - S_FRAC_W;           // 29
  localparam int S_BIAS    = 127;
  localparam int D_BIAS    = 1023;
  localparam int BIAS_ADJ  = D_BIAS - S_BIAS;               // 896
  localparam int CR_W      = 4;
  localparam int LZ_W      = $clog2(S_FRAC_W + 1);

  typedef struct packed {
    logic                sign;
    logic [S_EXP_W-1:0]  exp;
    logic [S_FRAC_W-1:0] frac;
  } sp_t;

  typedef struct packed {
    logic                sign;
    logic [D_EXP_W-1:0]  exp;
    logic [D_FRAC_W-1:0] frac;
  } dp_t;

  typedef enum logic [1:0] {
    K_SPECIAL = 2'd0,
    K_NORMAL  = 2'd1,
    K_ZERO    = 2'd2,
    K_DENORM  = 2'd3
  } sp_kind_e;
endpackage

// File: rtl/fmv_lzc.sv
`timescale 1ns/1ps
module fmv_lzc #(
  parameter int WIDTH = 23,
  parameter int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic [WIDTH-1:0] vec,
  output logic [CNT_W-1:0] count
);
  // Scan from the bottom; the highest set bit writes last and wins.
  always_comb begin
    count = CNT_W'(WIDTH);
    for (int i = 0; i < WIDTH; i++) begin
      if (vec[i]) count = CNT_W'(WIDTH - 1 - i);
    end
  end
endmodule

// File: rtl/fmv_widen.sv
`timescale 1ns/1ps
module fmv_widen
  import fmv_pkg::*;
(
  input  logic [SW-1:0] sp_bits,
  output logic [DW-1:0] dp_bits
);
  sp_t                 sp;
  dp_t                 dp;
  sp_kind_e            kind;
  logic [LZ_W-1:0]     lz;
  logic [LZ_W-1:0]     shamt;
  logic [S_FRAC_W-1:0] norm_frac;

  assign sp = sp_t'(sp_bits);

  always_comb begin
    if (sp.exp == {S_EXP_W{1'b1}})      kind = K_SPECIAL;
    else if (sp.exp != '0)              kind = K_NORMAL;
    else if (sp.frac == '0)             kind = K_ZERO;
    else                                kind = K_DENORM;
  end

  fmv_lzc #(.WIDTH(S_FRAC_W), .CNT_W(LZ_W)) u_lzc (
    .vec   (sp.frac),
    .count (lz)
  );

  assign shamt     = lz + LZ_W'(1);
  assign norm_frac = sp.frac << shamt;

  always_comb begin
    dp.sign = sp.sign;
    dp.exp  = '0;
    dp.frac = '0;
    unique case (kind)
      K_SPECIAL: begin
        dp.exp  = {D_EXP_W{1'b1}};
        dp.frac = {sp.frac, {FRAC_PAD{1'b0}}};
      end
      K_NORMAL: begin
        dp.exp  = D_EXP_W'(sp.exp) + D_EXP_W'(BIAS_ADJ);
        dp.frac = {sp.frac, {FRAC_PAD{1'b0}}};
      end
      K_ZERO: begin
        dp.exp  = '0;
        dp.frac = '0;
      end
      K_DENORM: begin
        dp.exp  = D_EXP_W'(BIAS_ADJ) - D_EXP_W'(lz);
        dp.frac = {norm_frac, {FRAC_PAD{1'b0}}};
      end
      default: ;
    endcase
  end

  assign dp_bits = DW'(dp);
endmodule

// File: rtl/fmv_crgen.sv
`timescale 1ns/1ps
module fmv_crgen
  import fmv_pkg::*;
(
  input  logic [DW-1:0]   value,
  input  logic            so,
  output logic [CR_W-1:0] cr
);
  logic lt, gt, eq;
  assign lt = value[DW-1];
  assign eq = (value == '0);
  assign gt = !lt && !eq;
  assign cr = {lt, gt, eq, so};
endmodule

// File: rtl/fmv_gpr2fpr.sv
`timescale 1ns/1ps
module fmv_gpr2fpr
  import fmv_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [63:0]     in_data,
  input  logic            in_single,
  input  logic            in_record,
  input  logic            in_so,
  output logic            out_valid,
  output logic [63:0]     out_data,
  output logic [3:0]      out_cr,
  output logic            out_cr_we
);
  logic [DW-1:0]   widened;
  logic [DW-1:0]   result;
  logic [CR_W-1:0] cr_next;

  fmv_widen u_widen (
    .sp_bits (in_data[SW-1:0]),
    .dp_bits (widened)
  );

  fmv_crgen u_crgen (
    .value (in_data),
    .so    (in_so),
    .cr    (cr_next)
  );

  assign result = in_single ? widened : in_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_cr_we <= 1'b0;
      out_data  <= '0;
      out_cr    <= '0;
    end else begin
      out_valid <= in_valid;
      out_cr_we <= in_valid && in_record;
      if (in_valid)              out_data <= result;
      if (in_valid && in_record) out_cr   <= cr_next;
    end
  end
endmodule

// File: rtl/fmv_gpr2fpr_chk.sv
`timescale 1ns/1ps
module fmv_gpr2fpr_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic [63:0] in_data,
  input logic        in_single,
  input logic        in_record,
  input logic        in_so,
  input logic        out_valid,
  input logic [63:0] out_data,
  input logic [3:0]  out_cr,
  input logic        out_cr_we
);
  p_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_single |=> out_data == $past(in_data));

  p_special_r3: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_single && in_data[30:23] == 8'hFF |=>
      out_data[62:52] == 11'h7FF && out_data[28:0] == 29'd0 &&
      out_data[51:29] == $past(in_data[22:0]) && out_data[63] == $past(in_data[31]));

  p_cr_fields_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_record |=> out_cr[3] == $past(in_data[63]) && out_cr[0] == $past(in_so));

  p_cr_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_cr_we |-> $countones(out_cr[3:1]) == 1);

  p_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_no_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_we_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_record |=> out_cr_we);

  p_no_we_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_record) |=> !out_cr_we);

  p_hold_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));

  p_hold_cr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_valid && in_record) |=> $stable(out_cr));
endmodule

bind fmv_gpr2fpr fmv_gpr2fpr_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_data   (in_data),
  .in_single (in_single),
  .in_record (in_record),
  .in_so     (in_so),
  .out_valid (out_valid),
  .out_data  (out_data),
  .out_cr    (out_cr),
  .out_cr_we (out_cr_we)
);

// File: tb/test_fmv_gpr2fpr.sv
`timescale 1ns/1ps
module test_fmv_gpr2fpr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_data = '0;
  logic        in_single = 1'b0;
  logic        in_record = 1'b0;
  logic        in_so = 1'b0;
  logic        out_valid;
  logic [63:0] out_data;
  logic [3:0]  out_cr;
  logic        out_cr_we;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fmv_gpr2fpr i_fmv_gpr2fpr (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_single(in_single), .in_record(in_record), .in_so(in_so),
    .out_valid(out_valid), .out_data(out_data), .out_cr(out_cr),
    .out_cr_we(out_cr_we)
  );

  // Reference: single to double, built from the numeric definition.
  function automatic logic [63:0] ref_widen(input logic [31:0] s);
    logic        sg;
    logic [7:0]  e;
    logic [23:0] m;
    int          de;
    sg = s[31]; e = s[30:23]; m = {1'b0, s[22:0]};
    if (e == 8'hFF) return {sg, 11'h7FF, s[22:0], 29'd0};
    if (e != 8'd0)  return {sg, 11'(int'(e) - 127 + 1023), s[22:0], 29'd0};
    if (m == 24'd0) return {sg, 63'd0};
    de = 897;
    while (!m[23]) begin
      m  = m << 1;
      de = de - 1;
    end
    return {sg, 11'(de), m[22:0], 29'd0};
  endfunction

  function automatic logic [3:0] ref_cr(input logic [63:0] v, input logic so);
    logic lt;
    lt = v[63];
    return {lt, (!lt && v != 64'd0), (v == 64'd0), so};
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Offer one operation; returns after the result cycle has been reached.
  task automatic apply(input logic [63:0] d, input logic sgl, input logic rec, input logic so);
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_single = sgl; in_record = rec; in_so = so;
    @(negedge clk);
    in_valid = 1'b0; in_data = 64'hDEAD_0BAD_F00D_CAFE; in_record = 1'b0; in_so = 1'b0;
  endtask

  task automatic t_reset;
    chk("R10 out_valid", 64'(out_valid), 64'd0);
    chk("R10 out_cr_we", 64'(out_cr_we), 64'd0);
    chk("R10 out_data", out_data, 64'd0);
    chk("R10 out_cr", 64'(out_cr), 64'd0);
  endtask

  task automatic t_pass64;
    logic [63:0] pats [5] = '{64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h7FF8_0000_0000_0001,
                              64'h0123_4567_89AB_CDEF, 64'h8000_0000_7F80_0000};
    foreach (pats[i]) begin
      apply(pats[i], 1'b0, 1'b0, 1'b0);
      chk("R1 pass-through", out_data, pats[i]);
      chk("R8 out_valid", 64'(out_valid), 64'd1);
      chk("R8 no cr_we", 64'(out_cr_we), 64'd0);
    end
  endtask

  task automatic t_upper_ignored;
    apply(64'h0000_0000_3F80_0000, 1'b1, 1'b0, 1'b0);
    chk("R2 upper zero", out_data, 64'h3FF0_0000_0000_0000);
    apply(64'hFFFF_FFFF_3F80_0000, 1'b1, 1'b0, 1'b0);
    chk("R2 upper ones", out_data, 64'h3FF0_0000_0000_0000);
    apply(64'hA5A5_1234_C040_0000, 1'b1, 1'b0, 1'b0);
    chk("R2 upper mixed", out_data, 64'hC008_0000_0000_0000);
  endtask

  task automatic t_special;
    apply(64'h1111_0000_7F80_0000, 1'b1, 1'b0, 1'b0);
    chk("R3 +inf", out_data, 64'h7FF0_0000_0000_0000);
    apply(64'h0000_0000_FF80_0000, 1'b1, 1'b0, 1'b0);
    chk("R3 -inf", out_data, 64'hFFF0_0000_0000_0000);
    apply(64'h0000_0000_FFC0_0001, 1'b1, 1'b0, 1'b0);
    chk("R3 nan payload", out_data, 64'hFFF8_0000_2000_0000);
    apply(64'h0000_0000_7F80_0001, 1'b1, 1'b0, 1'b0);
    chk("R3 snan", out_data, ref_widen(32'h7F80_0001));
  endtask

  task automatic t_normal_zero;
    logic [31:0] pats [6] = '{32'h3F80_0000, 32'h0080_0000, 32'h7F7F_FFFF,
                              32'hBEAA_AAAB, 32'h0000_0000, 32'h8000_0000};
    foreach (pats[i]) begin
      apply({32'h5555_AAAA, pats[i]}, 1'b1, 1'b0, 1'b0);
      chk("R4 normal/zero", out_data, ref_widen(pats[i]));
    end
    chk("R4 -0 sign", out_data, 64'h8000_0000_0000_0000);
  endtask

  task automatic t_denorm;
    for (int k = 0; k < 23; k++) begin
      apply({32'h0F0F_F0F0, 9'd0, 23'd1 << k}, 1'b1, 1'b0, 1'b0);
      chk("R5 denorm one-hot", out_data, ref_widen({9'd0, 23'd1 << k}));
    end
    apply(64'h0000_0000_0000_0001, 1'b1, 1'b0, 1'b0);
    chk("R5 min denorm", out_data, 64'h36A0_0000_0000_0000);
    apply(64'h0000_0000_807F_FFFF, 1'b1, 1'b0, 1'b0);
    chk("R5 max denorm", out_data, 64'hB80F_FFFF_C000_0000);
    apply(64'h0000_0000_0000_0003, 1'b1, 1'b0, 1'b0);
    chk("R5 low dense", out_data, ref_widen(32'h0000_0003));
  endtask

  task automatic t_cr;
    logic [63:0] pats [4] = '{64'h0, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001,
                              64'h7FFF_FFFF_FFFF_FFFF};
    foreach (pats[i]) begin
      for (int so = 0; so < 2; so++) begin
        apply(pats[i], 1'b0, 1'b1, 1'(so));
        chk("R6 cr field", 64'(out_cr), 64'(ref_cr(pats[i], 1'(so))));
        chk("R8 cr_we on record", 64'(out_cr_we), 64'd1);
      end
    end
  endtask

  task automatic t_cr_single;
    apply(64'h8000_0000_0000_0000, 1'b1, 1'b1, 1'b0);
    chk("R7 single lt from bit63", 64'(out_cr), 64'b1000);
    chk("R7 data is +0", out_data, 64'd0);
    apply(64'h0000_0001_0000_0000, 1'b1, 1'b1, 1'b1);
    chk("R7 single gt from upper", 64'(out_cr), 64'b0101);
    apply(64'h0000_0000_0000_0000, 1'b1, 1'b1, 1'b0);
    chk("R7 single eq", 64'(out_cr), 64'b0010);
  endtask

  task automatic t_norecord_hold;
    apply(64'hF000_0000_0000_0000, 1'b0, 1'b1, 1'b1);
    chk("R6 negative", 64'(out_cr), 64'b1001);
    apply(64'h0, 1'b0, 1'b0, 1'b0);
    chk("R9 cr held w/o record", 64'(out_cr), 64'b1001);
    chk("R8 no cr_we w/o record", 64'(out_cr_we), 64'd0);
    chk("R1 data updated", out_data, 64'd0);
  endtask

  task automatic t_idle_hold;
    apply(64'h1234_5678_9ABC_DEF0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      in_data = {32'd0, 32'(i) * 32'h0101_0101};
      in_so   = 1'b1;
      chk("R9 data held idle", out_data, 64'h1234_5678_9ABC_DEF0);
      chk("R9 cr held idle", 64'(out_cr), 64'b0100);
      chk("R8 valid low idle", 64'(out_valid), 64'd0);
      chk("R8 cr_we low idle", 64'(out_cr_we), 64'd0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pass64();
    t_upper_ignored();
    t_special();
    t_normal_zero();
    t_denorm();
    t_cr();
    t_cr_single();
    t_norecord_hold();
    t_idle_hold();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule